// File: doc/BRIEF.md
# Nibble-Wide Link Port with Word Packing

This block is one end of a point-to-point link that carries data words over a 4-bit data path. A strobe line from the sender and an acknowledge line from the receiver control the flow. Every transition of the strobe, rising or falling, carries one nibble, so one full strobe period moves 8 bits. A configuration input selects 32-bit words (8 nibbles) or 48-bit words (12 nibbles). Both ends of a link must use the same setting.

A role input sets the port as a transmitter or a receiver. In transmit mode the local side writes a word into a holding register. The port copies it into a shift register and sends it nibble by nibble, least-significant nibble first. It starts a new word only when the far end acknowledges. In receive mode the arriving nibbles are assembled in a shift register and passed to a holding register that the local side reads. Because there are two stages, a second word can arrive while the first one waits to be read. Each side reports whether its holding register is full.

Both ends run on the same system clock. The strobe is a level that toggles, and the receiver detects each toggle synchronously.

Top module: `nib_link_port`

## Requirements
- R1: After a synchronous active-low reset, `tx_full_o` and `rx_full_o` are 0 and `lnk_clk_o` and `lnk_dat_o` are 0. A port in receive role drives `lnk_ack_o` high, and a port in transmit role drives it low.
- R2: The transmitter toggles `lnk_clk_o` exactly once for each nibble it sends. A word takes 8 toggles when `cfg_wide`=0 and 12 toggles when `cfg_wide`=1.
- R3: Nibbles leave least-significant first. The nibble on `lnk_dat_o` at toggle k is bits [4k+3:4k] of the word.
- R4: In 32-bit mode only bits [31:0] of a transmitted word are sent, and a received word has bits [47:32] equal to 0.
- R5: A transmitter connected to a receiver delivers every accepted word, intact and in write order.
- R6: `tx_wr_i` is accepted only while `tx_full_o` is 0. A write while the register is full is dropped and never appears on the link.
- R7: The transmitter starts a word only when `lnk_ack_i` is 1 at a word boundary. Otherwise `lnk_clk_o` holds its level.
- R8: The receiver holds one word in its holding register and a second word in its shift register. It drops `lnk_ack_o` when the holding register is full and another word is arriving or complete. A read (`rx_rd_i` while `rx_full_o`=1) moves the waiting word forward and raises `lnk_ack_o` again.
- R9: `cfg_tx`=1 selects transmit and `cfg_tx`=0 selects receive. In receive role `tx_wr_i` has no effect: `tx_full_o` stays 0 and `lnk_clk_o` stays still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx | input | 1 | 1 = transmit role, 0 = receive role |
| cfg_wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 48 | Word to transmit |
| tx_full_o | output | 1 | Transmit holding register full |
| lnk_dat_o | output | 4 | Outgoing nibble |
| lnk_clk_o | output | 1 | Outgoing strobe; each toggle marks a nibble |
| lnk_ack_i | input | 1 | Acknowledge from the far receiver |
| lnk_dat_i | input | 4 | Incoming nibble |
| lnk_clk_i | input | 1 | Incoming strobe |
| lnk_ack_o | output | 1 | Acknowledge to the far transmitter |
| rx_rd_i | input | 1 | Read strobe for the receive holding register |
| rx_data_o | output | 48 | Received word |
| rx_full_o | output | 1 | Receive holding register full |

## Verification
A wrong nibble counter shows up within one word as a wrong number of strobe toggles or as a received word with shifted or missing nibbles. An error in the receive stage or holding-register handover appears at the next read as a lost, duplicated or reordered word. If the receiver raises acknowledge too early, the transmitter starts a word into a full receiver, and that word is later missing from the read-out sequence. If acknowledge is ignored, the strobe keeps toggling during a stall window of a few cycles.

// File: rtl/nlp_pkg.sv
// Shared sizes for the nibble link port.
package nlp_pkg;
    localparam int unsigned NIB_W       = 4;
    localparam int unsigned NIBS_NARROW = 8;
    localparam int unsigned NIBS_WIDE   = 12;
    localparam int unsigned WORD_W      = NIB_W * NIBS_WIDE;
    localparam int unsigned CNT_W       = $clog2(NIBS_WIDE + 1);
endpackage

// File: rtl/nlp_tx.sv
// Transmit half: a holding register that the local side writes, and a shift
// register that sends one nibble per strobe toggle, low nibble first.
// Assumes cfg_wide is changed only while the link is idle. A word already
// being shifted out always finishes, even if the role changes.
module nlp_tx
    import nlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wide,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              full_o,
    output logic [NIB_W-1:0]  dat_o,
    output logic              strb_o,
    input  logic              ack_i
);
    logic [WORD_W-1:0] hold_q, sh_q;
    logic              hold_full_q, strb_q;
    logic [CNT_W-1:0]  cnt_q, nibs;
    logic [NIB_W-1:0]  dat_q;
    logic              load;

    // nibble count per word for the selected width
    assign nibs = wide ? CNT_W'(NIBS_WIDE) : CNT_W'(NIBS_NARROW);
    // start a word only at a boundary with data waiting and the far end ready
    assign load = en && hold_full_q && (cnt_q == '0) && ack_i;

    // holding register: accept a write only while empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (load) begin
            hold_full_q <= 1'b0;
        end else if (en && wr_i && !hold_full_q) begin
            hold_q      <= data_i;
            hold_full_q <= 1'b1;
        end
    end

    // shift register and strobe: one nibble and one toggle per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            dat_q  <= '0;
            strb_q <= 1'b0;
        end else if (load) begin
            dat_q  <= hold_q[NIB_W-1:0];
            strb_q <= ~strb_q;
            sh_q   <= hold_q >> NIB_W;
            cnt_q  <= nibs - CNT_W'(1);
        end else if (cnt_q != '0) begin
            dat_q  <= sh_q[NIB_W-1:0];
            strb_q <= ~strb_q;
            sh_q   <= sh_q >> NIB_W;
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign full_o = hold_full_q;
    assign dat_o  = dat_q;
    assign strb_o = strb_q;

    // R7: at an idle boundary without acknowledge the strobe does not move
    a_r7_idle_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !ack_i) |=> $stable(strb_q));
    // R2: every nibble still pending produces a strobe toggle
    a_r2_toggle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (strb_q != $past(strb_q)));
    // R6: a full holding register keeps its contents
    a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        hold_full_q |=> $stable(hold_q));
endmodule

// File: rtl/nlp_rx.sv
// Receive half: detects each strobe toggle and places the nibble at its slot
// in a shift register. A finished word moves on to a holding register that
// the local side reads. Assumes the strobe comes from the same clock domain.
module nlp_rx
    import nlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wide,
    input  logic [NIB_W-1:0]  dat_i,
    input  logic              strb_i,
    output logic              ack_o,
    input  logic              rd_i,
    output logic [WORD_W-1:0] data_o,
    output logic              full_o
);
    logic [WORD_W-1:0] sh_q, sh_nx, hold_q;
    logic              sh_full_q, hold_full_q, strb_q;
    logic [CNT_W-1:0]  cnt_q, nibs;
    logic              edge_seen, done, take, hold_avail;

    assign nibs       = wide ? CNT_W'(NIBS_WIDE) : CNT_W'(NIBS_NARROW);
    assign edge_seen  = en && (strb_i != strb_q);
    assign done       = edge_seen && (cnt_q == nibs - CNT_W'(1));
    assign take       = rd_i && hold_full_q;
    assign hold_avail = !hold_full_q || take;

    // next shift contents: clear at the start of a word, then place the nibble
    always_comb begin
        sh_nx = (cnt_q == '0) ? '0 : sh_q;
        sh_nx[int'(cnt_q) * NIB_W +: NIB_W] = dat_i;
    end

    // strobe history and nibble assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            sh_q   <= '0;
            cnt_q  <= '0;
        end else begin
            strb_q <= strb_i;
            if (edge_seen) begin
                sh_q  <= sh_nx;
                cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    // pass finished words from the shift stage to the holding stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            sh_full_q   <= 1'b0;
        end else if (sh_full_q && hold_avail) begin
            hold_q      <= sh_q;
            hold_full_q <= 1'b1;
            sh_full_q   <= 1'b0;
        end else if (done && hold_avail) begin
            hold_q      <= sh_nx;
            hold_full_q <= 1'b1;
        end else if (done) begin
            sh_full_q   <= 1'b1;
        end else if (take) begin
            hold_full_q <= 1'b0;
        end
    end

    // hold acknowledge low while the holding stage is full and a word is in the shift stage
    assign ack_o  = en && !(hold_full_q && (sh_full_q || cnt_q != '0));
    assign data_o = hold_q;
    assign full_o = hold_full_q;

    // R8: a word never completes into an occupied shift stage
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sh_full_q);
    // R8: an unread holding register keeps its word
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full_q && !rd_i) |=> (hold_full_q && $stable(hold_q)));
endmodule

// File: rtl/nib_link_port.sv
// Link port top: a transmit half and a receive half. The role input
// enables exactly one of them.
module nib_link_port
    import nlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx,
    input  logic              cfg_wide,
    input  logic              tx_wr_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_full_o,
    output logic [NIB_W-1:0]  lnk_dat_o,
    output logic              lnk_clk_o,
    input  logic              lnk_ack_i,
    input  logic [NIB_W-1:0]  lnk_dat_i,
    input  logic              lnk_clk_i,
    output logic              lnk_ack_o,
    input  logic              rx_rd_i,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_full_o
);
    nlp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(cfg_tx), .wide(cfg_wide),
        .wr_i(tx_wr_i), .data_i(tx_data_i), .full_o(tx_full_o),
        .dat_o(lnk_dat_o), .strb_o(lnk_clk_o), .ack_i(lnk_ack_i)
    );

    nlp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(!cfg_tx), .wide(cfg_wide),
        .dat_i(lnk_dat_i), .strb_i(lnk_clk_i), .ack_o(lnk_ack_o),
        .rd_i(rx_rd_i), .data_o(rx_data_o), .full_o(rx_full_o)
    );

    // R9: a transmit-role port never acknowledges
    a_r9_no_ack_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx |-> !lnk_ack_o);
endmodule

// File: tb/nib_link_port_tb_top.sv
// Scoreboard bench: dut_i transmits to peer_i, which receives.
module nib_link_port_tb_top;
    import nlp_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              dut_role = 1'b1, wide = 1'b0;
    logic              tx_wr = 1'b0, peer_rd = 1'b0, mon_en = 1'b0;
    logic [WORD_W-1:0] tx_data = '0;
    logic              d_tx_full, d_lclk, d_ack, d_rx_full;
    logic [NIB_W-1:0]  d_ldat;
    logic [WORD_W-1:0] d_rx_data;
    logic              p_tx_full, p_lclk, p_ack, p_rx_full;
    logic [NIB_W-1:0]  p_ldat;
    logic [WORD_W-1:0] p_rx_data;

    nib_link_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tx(dut_role), .cfg_wide(wide),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(d_tx_full),
        .lnk_dat_o(d_ldat), .lnk_clk_o(d_lclk), .lnk_ack_i(p_ack),
        .lnk_dat_i(4'h0), .lnk_clk_i(1'b0), .lnk_ack_o(d_ack),
        .rx_rd_i(1'b0), .rx_data_o(d_rx_data), .rx_full_o(d_rx_full)
    );

    nib_link_port peer_i (
        .clk(clk), .rst_n(rst_n), .cfg_tx(1'b0), .cfg_wide(wide),
        .tx_wr_i(1'b0), .tx_data_i('0), .tx_full_o(p_tx_full),
        .lnk_dat_o(p_ldat), .lnk_clk_o(p_lclk), .lnk_ack_i(1'b0),
        .lnk_dat_i(d_ldat), .lnk_clk_i(d_lclk), .lnk_ack_o(p_ack),
        .rx_rd_i(peer_rd), .rx_data_o(p_rx_data), .rx_full_o(p_rx_full)
    );

    int errs = 0, checks = 0;
    logic [WORD_W-1:0] exp_q[$];

    task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // strobe tap: count toggles on the outgoing link and log each nibble
    int unsigned      tog_total = 0;
    logic             last_clk = 1'b0;
    logic [NIB_W-1:0] nib_log[64];
    always @(negedge clk) begin
        if (d_lclk !== last_clk) begin
            nib_log[tog_total % 64] = d_ldat;
            tog_total = tog_total + 1;
        end
        last_clk = d_lclk;
    end

    // monitor: read the receiver and compare against the scoreboard (R4, R5)
    always @(negedge clk) begin
        peer_rd = 1'b0;
        if (mon_en && p_rx_full) begin
            if (exp_q.size() == 0) chk("R5 unexpected word", p_rx_data, '1);
            else chk("R4/R5 received word", p_rx_data, exp_q.pop_front());
            peer_rd = 1'b1;
        end
    end

    // driver: write one word when the holding register is free
    task automatic put(input logic [WORD_W-1:0] w);
        @(negedge clk);
        while (d_tx_full) @(negedge clk);
        tx_wr = 1'b1; tx_data = w;
        @(negedge clk);
        tx_wr = 1'b0;
        exp_q.push_back(wide ? w : {{(WORD_W-32){1'b0}}, w[31:0]});
    endtask

    task automatic drain();
        repeat (200) @(negedge clk);
        chk("R5 queue drained", WORD_W'(exp_q.size()), '0);
    endtask

    initial begin
        #(4 * 150000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int unsigned start;
        logic        held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_full", WORD_W'(d_tx_full), '0);
        chk("R1 lnk_clk", WORD_W'(d_lclk), '0);
        chk("R1 lnk_dat", WORD_W'(d_ldat), '0);
        chk("R1 rx_full", WORD_W'(p_rx_full), '0);
        chk("R1 rx ack high", WORD_W'(p_ack), 1);
        chk("R1/R9 tx ack low", WORD_W'(d_ack), '0);

        mon_en = 1'b1;
        // 32-bit word: 8 toggles, low nibble first, upper bits discarded
        wide = 1'b0; start = tog_total;
        put(48'hABCD_8765_4321);
        repeat (30) @(negedge clk);
        chk("R2 narrow toggles", WORD_W'(tog_total - start), 8);
        chk("R3 first nibble", WORD_W'(nib_log[start % 64]), 48'h1);
        chk("R3 eighth nibble", WORD_W'(nib_log[(start + 7) % 64]), 48'h8);

        // 48-bit word: 12 toggles
        wide = 1'b1; start = tog_total;
        put(48'h9FED_CBA9_8765);
        repeat (30) @(negedge clk);
        chk("R2 wide toggles", WORD_W'(tog_total - start), 12);
        chk("R3 first nibble wide", WORD_W'(nib_log[start % 64]), 48'h5);
        chk("R3 last nibble wide", WORD_W'(nib_log[(start + 11) % 64]), 48'h9);

        // back-to-back stream in wide mode
        for (int i = 0; i < 6; i++) put(48'h1357_9BDF_0246 * (i + 3) ^ {8{6'(i)}});
        drain();
        wide = 1'b0;
        for (int i = 0; i < 5; i++) put(48'h0000_C0DE_0000 + 48'(i * 32'h1111_1111));
        drain();

        // stall the receiver: two words stored, third waits in tx holding register
        wide = 1'b1; mon_en = 1'b0;
        put(48'h1111_2222_3333);
        put(48'h4444_5555_6666);
        put(48'h7777_8888_9999);
        repeat (60) @(negedge clk);
        chk("R8 rx full while stalled", WORD_W'(p_rx_full), 1);
        chk("R8 ack low when both stages full", WORD_W'(p_ack), '0);
        chk("R6/R7 tx holding kept", WORD_W'(d_tx_full), 1);
        // R6: write while full is dropped (not pushed to the scoreboard)
        tx_wr = 1'b1; tx_data = 48'hDEAD_DEAD_DEAD;
        @(negedge clk);
        tx_wr = 1'b0;
        held = d_lclk;
        repeat (10) @(negedge clk);
        chk("R7 strobe held without ack", WORD_W'(d_lclk), WORD_W'(held));
        // one read, then acknowledge must return
        @(posedge clk); #1 mon_en = 1'b1;
        @(negedge clk); #1 mon_en = 1'b0;
        @(posedge clk); #1;
        chk("R8 ack back after read", WORD_W'(p_ack), 1);
        mon_en = 1'b1;
        drain();

        // receive role: transmit writes are ignored
        dut_role = 1'b0;
        repeat (2) @(negedge clk);
        held = d_lclk;
        tx_wr = 1'b1; tx_data = 48'h0BAD_0BAD_0BAD;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 tx_full stays low", WORD_W'(d_tx_full), '0);
        chk("R9 strobe still", WORD_W'(d_lclk), WORD_W'(held));
        chk("R9 rx role ack high", WORD_W'(d_ack), 1);
        chk("R9 nothing received", WORD_W'(p_rx_full), '0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule